// File: doc/BRIEF.md
# Dual-mode program counter state unit

This block keeps the architectural program counter state of a 32-bit processor that runs in two instruction encodings: a wide one with 4-byte steps and a compact one with 2-byte steps. A third flag, the extension flag, combined with the compact flag selects a restricted sub-state. The unit holds the current and pending PC and a micro-op index with its pending value. Each mode flag has a current copy and a pending copy. The pending copy becomes current when the processor moves to its next instruction.

One command per cycle changes the state. The commands are: load a PC, step to the next instruction, close a micro-op sequence, take a plain branch, take a mode-switching branch, or take a mode-switching branch that applies only in the wide mode. A mode-switching branch reads the low bits of its target to choose the next encoding. Targets that are not valid give a one-cycle error or warning strobe. The unit also gives the PC as an instruction operand sees it, which is ahead of the fetch address by a mode-dependent amount.

Top module: `pcs_state_unit`

## Requirements
- R1: After a synchronous active-low reset, every register is 0: PC, pending PC, micro-op index and its pending value, all four mode flags, and both strobes.
- R2: A load command (cmd bit 0) sets PC to cmd_val. It sets the pending PC to cmd_val+2 when the current compact flag is 1, and to cmd_val+4 otherwise. The micro-op index is not changed.
- R3: A step command (cmd bit 1) copies the pending PC into PC. The new pending PC is the old pending PC plus 2 or plus 4, chosen by the current compact flag held before the step. The pending mode flags, as held before the cycle, then become the current flags.
- R4: A step command sets the micro-op index to its pending value, and sets the pending value to that pending value plus 1 (modulo 2^UPC_W).
- R5: A sequence-end command (cmd bit 2) updates the PC and the flags as R3 does. It then sets the micro-op index to 0 and its pending value to 1.
- R6: opnd_pc equals PC+4 while the current compact flag is 1, and PC+8 otherwise.
- R7: A plain branch (cmd bit 3) writes the pending PC with the target. Bit 0 is cleared if the pending compact flag held before the cycle is 1. Bits 1:0 are cleared otherwise.
- R8: A mode-switching branch (cmd bit 4) taken while both current flags are 1 needs target bit 0 = 1. It then writes the target with bit 0 cleared. If bit 0 is 0, it raises err_stb and leaves the pending PC unchanged.
- R9: A mode-switching branch taken outside that state has two valid cases. A target with bit 0 = 1 sets the pending compact flag and writes the target with bit 0 cleared. A target with bits 1:0 = 00 clears the pending compact flag and writes the target unchanged.
- R10: Outside that state, a target with bits 1:0 = 10 raises warn_stb. The pending compact flag is kept and the target is written unchanged. err_stb and warn_stb are never both 1.
- R11: A conditional branch (cmd bit 5) acts as R8 to R10 when both current flags are 0, and as R7 otherwise.
- R12: When more than one cmd bit is 1, only the lowest-numbered one takes effect.
- R13: wr_next_c_en and wr_next_x_en load the pending flags from wr_next_c and wr_next_x in any cycle. A mode-switching branch that sets or clears the pending compact flag wins over a direct write in the same cycle.
- R14: err_stb and warn_stb are 1 only in the cycle after a mode-switching or conditional branch that produced them. Each lasts one cycle for each such command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 6 | Command request bits: 0 load, 1 step, 2 sequence end, 3 plain branch, 4 mode-switching branch, 5 conditional branch |
| cmd_val | input | ADDR_W | Load value or branch target |
| wr_next_c_en | input | 1 | Write enable for the pending compact flag |
| wr_next_c | input | 1 | Value for the pending compact flag |
| wr_next_x_en | input | 1 | Write enable for the pending extension flag |
| wr_next_x | input | 1 | Value for the pending extension flag |
| pc | output | ADDR_W | Current PC |
| npc | output | ADDR_W | Pending PC |
| opnd_pc | output | ADDR_W | PC as seen by an instruction operand |
| uop_idx | output | UPC_W | Micro-op index |
| uop_nxt | output | UPC_W | Pending micro-op index |
| mode_c | output | 1 | Current compact flag |
| mode_x | output | 1 | Current extension flag |
| next_c | output | 1 | Pending compact flag |
| next_x | output | 1 | Pending extension flag |
| err_stb | output | 1 | Invalid target in the restricted state |
| warn_stb | output | 1 | Malformed target outside the restricted state |

## Verification
Every register, the two strobes included, takes its new value at the first rising edge after the command is applied. opnd_pc follows combinationally from the registers, so all results are due one cycle after the stimulus. The driver applies a command at a falling edge and queues the full expected state for that cycle. The monitor compares it 2 ns after the next rising edge, so each comparison sees exactly one edge's worth of update. Idle cycles between commands check that the strobes drop and that state not addressed by a command stays unchanged.

// File: rtl/pcs_pkg.sv
// Package: command bit positions and mode-dependent step sizes shared by
// the program counter state unit and its sub-blocks.
package pcs_pkg;
    localparam int CI_LOAD  = 0;
    localparam int CI_STEP  = 1;
    localparam int CI_UEND  = 2;
    localparam int CI_PLAIN = 3;
    localparam int CI_SWBR  = 4;
    localparam int CI_COND  = 5;
    localparam int NCMD     = 6;

    // Sequential increment: 2 bytes in compact mode, 4 in wide mode.
    function automatic logic [3:0] seq_step(input logic compact);
        return compact ? 4'd2 : 4'd4;
    endfunction

    // Distance from fetch PC to operand-visible PC.
    function automatic logic [3:0] opnd_off(input logic compact);
        return compact ? 4'd4 : 4'd8;
    endfunction
endpackage

// File: rtl/pcs_cmd_arbiter.sv
// Fixed-priority picker: passes on the lowest-numbered request bit only.
// Assumes nothing about the request pattern; purely combinational.
module pcs_cmd_arbiter #(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // One stage per request: granted if no lower bit was requested.
    generate
        for (genvar i = 0; i < N; i++) begin : g_pri
            assign grant[i]    = req[i] & ~seen[i];
            assign seen[i + 1] = seen[i] | req[i];
        end
    endgenerate
endmodule

// File: rtl/pcs_branch_resolver.sv
// Branch target resolution: given the granted branch kind, the target and
// the mode flags, decides the pending PC write, any pending compact-flag
// change and the error or warning outcome. Assumes at most one of the
// do_* inputs is high (guaranteed by the arbiter). Combinational.
module pcs_branch_resolver #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] tgt,
    input  logic              cur_c,
    input  logic              cur_x,
    input  logic              nxt_c,
    input  logic              do_plain,
    input  logic              do_swbr,
    input  logic              do_cond,
    output logic              npc_we,
    output logic [ADDR_W-1:0] npc_val,
    output logic              mode_we,
    output logic              mode_val,
    output logic              err,
    output logic              warn
);
    logic use_plain;
    logic use_sw;
    logic restricted;

    assign restricted = cur_c & cur_x;
    assign use_sw     = do_swbr | (do_cond & ~cur_c & ~cur_x);
    assign use_plain  = do_plain | (do_cond & (cur_c | cur_x));

    // Pick the target alignment and mode update for the active branch kind.
    always_comb begin
        npc_we   = 1'b0;
        npc_val  = tgt;
        mode_we  = 1'b0;
        mode_val = 1'b0;
        err      = 1'b0;
        warn     = 1'b0;
        if (use_plain) begin
            npc_we  = 1'b1;
            npc_val = nxt_c ? {tgt[ADDR_W-1:1], 1'b0} : {tgt[ADDR_W-1:2], 2'b00};
        end else if (use_sw) begin
            if (restricted) begin
                if (tgt[0]) begin
                    npc_we  = 1'b1;
                    npc_val = {tgt[ADDR_W-1:1], 1'b0};
                end else begin
                    err = 1'b1;
                end
            end else if (tgt[0]) begin
                npc_we   = 1'b1;
                npc_val  = {tgt[ADDR_W-1:1], 1'b0};
                mode_we  = 1'b1;
                mode_val = 1'b1;
            end else if (!tgt[1]) begin
                npc_we   = 1'b1;
                mode_we  = 1'b1;
                mode_val = 1'b0;
            end else begin
                npc_we = 1'b1;
                warn   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcs_uop_counter.sv
// Micro-op index and its pending value. A step moves the pending value in
// and pre-increments it; a restart forces 0 and 1. Assumes step and
// restart are never high together.
module pcs_uop_counter #(
    parameter int UPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    output logic [UPC_W-1:0] idx,
    output logic [UPC_W-1:0] nxt
);
    localparam logic [UPC_W-1:0] ONE = UPC_W'(1);

    // Index update on step or sequence restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
            nxt <= '0;
        end else if (restart) begin
            idx <= '0;
            nxt <= ONE;
        end else if (step) begin
            idx <= nxt;
            nxt <= nxt + ONE;
        end
    end

    a_r4_step_takes_pending: assert property (@(posedge clk) disable iff (!rst_n)
        step && !restart |=> idx == $past(nxt) && nxt == $past(nxt) + ONE)
        else $error("R4 micro-op step");

    a_r5_restart_values: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> idx == '0 && nxt == ONE)
        else $error("R5 micro-op restart");
endmodule

// File: rtl/pcs_state_unit.sv
// Program counter state unit for a two-encoding processor. Holds PC,
// pending PC, current and pending mode flags (compact, extension) and the
// micro-op index. Accepts one command per cycle (lowest bit wins) and
// registers its results, including error and warning strobes.
// Assumes ADDR_W > 4.
module pcs_state_unit #(
    parameter int ADDR_W = 32,
    parameter int UPC_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [pcs_pkg::NCMD-1:0] cmd,
    input  logic [ADDR_W-1:0]       cmd_val,
    input  logic                    wr_next_c_en,
    input  logic                    wr_next_c,
    input  logic                    wr_next_x_en,
    input  logic                    wr_next_x,
    output logic [ADDR_W-1:0]       pc,
    output logic [ADDR_W-1:0]       npc,
    output logic [ADDR_W-1:0]       opnd_pc,
    output logic [UPC_W-1:0]        uop_idx,
    output logic [UPC_W-1:0]        uop_nxt,
    output logic                    mode_c,
    output logic                    mode_x,
    output logic                    next_c,
    output logic                    next_x,
    output logic                    err_stb,
    output logic                    warn_stb
);
    import pcs_pkg::*;

    localparam int PAD_W = ADDR_W - 4;

    logic [NCMD-1:0]   grant;
    logic              g_load, g_step, g_uend, g_plain, g_swbr, g_cond;
    logic              br_npc_we;
    logic [ADDR_W-1:0] br_npc_val;
    logic              br_mode_we;
    logic              br_mode_val;
    logic              br_err;
    logic              br_warn;
    logic [ADDR_W-1:0] step_amt;

    pcs_cmd_arbiter #(.N(NCMD)) u_arb (
        .req   (cmd),
        .grant (grant)
    );

    assign g_load  = grant[CI_LOAD];
    assign g_step  = grant[CI_STEP];
    assign g_uend  = grant[CI_UEND];
    assign g_plain = grant[CI_PLAIN];
    assign g_swbr  = grant[CI_SWBR];
    assign g_cond  = grant[CI_COND];

    pcs_branch_resolver #(.ADDR_W(ADDR_W)) u_br (
        .tgt      (cmd_val),
        .cur_c    (mode_c),
        .cur_x    (mode_x),
        .nxt_c    (next_c),
        .do_plain (g_plain),
        .do_swbr  (g_swbr),
        .do_cond  (g_cond),
        .npc_we   (br_npc_we),
        .npc_val  (br_npc_val),
        .mode_we  (br_mode_we),
        .mode_val (br_mode_val),
        .err      (br_err),
        .warn     (br_warn)
    );

    pcs_uop_counter #(.UPC_W(UPC_W)) u_uop (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (g_step),
        .restart (g_uend),
        .idx     (uop_idx),
        .nxt     (uop_nxt)
    );

    assign step_amt = {{PAD_W{1'b0}}, seq_step(mode_c)};
    assign opnd_pc  = pc + {{PAD_W{1'b0}}, opnd_off(mode_c)};

    // PC, pending PC and current flags: load, step/sequence end, branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc     <= '0;
            npc    <= '0;
            mode_c <= 1'b0;
            mode_x <= 1'b0;
        end else if (g_load) begin
            pc  <= cmd_val;
            npc <= cmd_val + step_amt;
        end else if (g_step || g_uend) begin
            pc     <= npc;
            npc    <= npc + step_amt;
            mode_c <= next_c;
            mode_x <= next_x;
        end else if (br_npc_we) begin
            npc <= br_npc_val;
        end
    end

    // Pending flags: branch mode update wins over a direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_c <= 1'b0;
            next_x <= 1'b0;
        end else begin
            if (br_mode_we)        next_c <= br_mode_val;
            else if (wr_next_c_en) next_c <= wr_next_c;
            if (wr_next_x_en)      next_x <= wr_next_x;
        end
    end

    // One-cycle outcome strobes of the branch resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_stb  <= 1'b0;
            warn_stb <= 1'b0;
        end else begin
            err_stb  <= br_err;
            warn_stb <= br_warn;
        end
    end

    a_r2_load_sets_pc: assert property (@(posedge clk) disable iff (!rst_n)
        g_load |=> pc == $past(cmd_val))
        else $error("R2 load");

    a_r3_step_moves_pending: assert property (@(posedge clk) disable iff (!rst_n)
        g_step |=> pc == $past(npc))
        else $error("R3 step pc");

    a_r3_flags_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (g_step || g_uend) |=> mode_c == $past(next_c) && mode_x == $past(next_x))
        else $error("R3 flag copy");

    a_r7_plain_even: assert property (@(posedge clk) disable iff (!rst_n)
        g_plain |=> npc[0] == 1'b0)
        else $error("R7 plain alignment");

    a_r14_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |-> $past(g_swbr || g_cond))
        else $error("R14 err cause");

    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_stb && warn_stb))
        else $error("R10 strobe overlap");
endmodule

// File: tb/tb_pcs_state_unit.sv
`timescale 1ns/1ps
module tb_pcs_state_unit;
    localparam int AW = 32;
    localparam int UW = 8;

    typedef struct {
        logic [AW-1:0] pc, npc, opc;
        logic [UW-1:0] ui, un;
        logic          c, x, nc, nx, err, warn;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    cmd = '0;
    logic [AW-1:0] cmd_val = '0;
    logic          wce = 1'b0, wcv = 1'b0, wxe = 1'b0, wxv = 1'b0;
    logic [AW-1:0] pc, npc, opnd_pc;
    logic [UW-1:0] uop_idx, uop_nxt;
    logic          mode_c, mode_x, next_c, next_x, err_stb, warn_stb;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    // Bench model state, built from the requirements.
    logic [AW-1:0] m_pc = '0, m_npc = '0;
    logic [UW-1:0] m_ui = '0, m_un = '0;
    logic          m_c = 1'b0, m_x = 1'b0, m_nc = 1'b0, m_nx = 1'b0;

    always #4 clk = ~clk;

    pcs_state_unit #(.ADDR_W(AW), .UPC_W(UW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cmd_val(cmd_val),
        .wr_next_c_en(wce), .wr_next_c(wcv), .wr_next_x_en(wxe), .wr_next_x(wxv),
        .pc(pc), .npc(npc), .opnd_pc(opnd_pc), .uop_idx(uop_idx), .uop_nxt(uop_nxt),
        .mode_c(mode_c), .mode_x(mode_x), .next_c(next_c), .next_x(next_x),
        .err_stb(err_stb), .warn_stb(warn_stb)
    );

    function automatic logic [AW-1:0] plain_tgt(input logic [AW-1:0] v, input logic nc);
        return nc ? (v & ~32'h1) : (v & ~32'h3);
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected state.
    task automatic drive(input logic [5:0] c, input logic [AW-1:0] v,
                         input logic we_c, input logic vc, input logic we_x, input logic vx,
                         input string tag);
        logic [AW-1:0] n_pc, n_npc;
        logic [UW-1:0] n_ui, n_un;
        logic          n_c, n_x, n_nc, n_nx, e_err, e_warn, sw;
        exp_t          e;
        @(negedge clk);
        cmd = c; cmd_val = v; wce = we_c; wcv = vc; wxe = we_x; wxv = vx;
        n_pc = m_pc; n_npc = m_npc; n_ui = m_ui; n_un = m_un;
        n_c = m_c; n_x = m_x; n_nc = m_nc; n_nx = m_nx;
        e_err = 1'b0; e_warn = 1'b0; sw = 1'b0;
        if (we_c) n_nc = vc;
        if (we_x) n_nx = vx;
        if (c[0]) begin
            n_pc = v; n_npc = v + (m_c ? 32'd2 : 32'd4);
        end else if (c[1] || c[2]) begin
            n_pc = m_npc; n_npc = m_npc + (m_c ? 32'd2 : 32'd4);
            n_c = m_nc; n_x = m_nx;
            if (c[1]) begin n_ui = m_un; n_un = m_un + 8'd1; end
            else begin n_ui = '0; n_un = 8'd1; end
        end else if (c[3]) begin
            n_npc = plain_tgt(v, m_nc);
        end else if (c[4] || (c[5] && !m_c && !m_x)) begin
            sw = 1'b1;
        end else if (c[5]) begin
            n_npc = plain_tgt(v, m_nc);
        end
        if (sw) begin
            if (m_c && m_x) begin
                if (v[0]) n_npc = v & ~32'h1;
                else e_err = 1'b1;
            end else if (v[0]) begin
                n_nc = 1'b1; n_npc = v & ~32'h1;
            end else if (!v[1]) begin
                n_nc = 1'b0; n_npc = v;
            end else begin
                e_warn = 1'b1; n_npc = v;
            end
        end
        e.pc = n_pc; e.npc = n_npc; e.opc = n_pc + (n_c ? 32'd4 : 32'd8);
        e.ui = n_ui; e.un = n_un; e.c = n_c; e.x = n_x; e.nc = n_nc; e.nx = n_nx;
        e.err = e_err; e.warn = e_warn; e.tag = tag;
        q.push_back(e);
        m_pc = n_pc; m_npc = n_npc; m_ui = n_ui; m_un = n_un;
        m_c = n_c; m_x = n_x; m_nc = n_nc; m_nx = n_nx;
    endtask

    task automatic idle(input string tag);
        drive(6'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare each queued item 2 ns after the edge that produced it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if ({pc, npc, opnd_pc, uop_idx, uop_nxt, mode_c, mode_x, next_c, next_x, err_stb, warn_stb} !==
                    {e.pc, e.npc, e.opc, e.ui, e.un, e.c, e.x, e.nc, e.nx, e.err, e.warn}) begin
                    n_fail++;
                    $display("FAIL %s: actual pc=%h npc=%h opc=%h ui=%0d un=%0d c=%b x=%b nc=%b nx=%b err=%b warn=%b expected pc=%h npc=%h opc=%h ui=%0d un=%0d c=%b x=%b nc=%b nx=%b err=%b warn=%b",
                        e.tag, pc, npc, opnd_pc, uop_idx, uop_nxt, mode_c, mode_x, next_c, next_x, err_stb, warn_stb,
                        e.pc, e.npc, e.opc, e.ui, e.un, e.c, e.x, e.nc, e.nx, e.err, e.warn);
                end
            end
        end
    end

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");
        drive(6'b000001, 32'h0000_1000, 0, 0, 0, 0, "R2 load wide, R6 operand +8");
        drive(6'b000010, '0, 0, 0, 0, 0, "R3 R4 step wide");
        drive(6'b000010, '0, 0, 0, 0, 0, "R4 second step");
        drive(6'b000100, '0, 0, 0, 0, 0, "R5 sequence end");
        drive(6'b001000, 32'h0000_2003, 0, 0, 0, 0, "R7 plain branch wide mask");
        drive(6'b010000, 32'h0000_3001, 0, 0, 0, 0, "R9 switch to compact");
        drive(6'b000010, '0, 0, 0, 0, 0, "R3 step uses old mode");
        drive(6'b000010, '0, 0, 0, 0, 0, "R3 R6 step in compact");
        drive(6'b000001, 32'h0000_4100, 0, 0, 0, 0, "R2 load compact");
        drive(6'b001000, 32'h0000_4003, 0, 0, 0, 0, "R7 plain branch compact mask");
        drive(6'b010000, 32'h0000_5002, 0, 0, 0, 0, "R10 malformed target warns");
        idle("R14 warn strobe drops");
        drive(6'b010000, 32'h0000_6000, 0, 0, 0, 0, "R9 switch to wide");
        drive(6'b100000, 32'h0000_7003, 0, 0, 0, 0, "R11 conditional acts plain in compact");
        drive(6'b000000, '0, 1, 1, 1, 1, "R13 direct pending flag writes");
        drive(6'b000010, '0, 0, 0, 0, 0, "R3 enter restricted state");
        drive(6'b010000, 32'h0000_8001, 0, 0, 0, 0, "R8 restricted valid target");
        drive(6'b010000, 32'h0000_8000, 0, 0, 0, 0, "R8 R14 restricted bad target");
        drive(6'b010000, 32'h0000_8800, 0, 0, 0, 0, "R14 back-to-back error");
        idle("R14 error strobe drops");
        drive(6'b000000, '0, 1, 0, 1, 0, "R13 clear pending flags");
        drive(6'b000010, '0, 0, 0, 0, 0, "R3 back to wide");
        drive(6'b010000, 32'h0000_9001, 1, 0, 0, 0, "R13 branch beats direct write");
        drive(6'b000000, '0, 1, 0, 0, 0, "R13 direct clear");
        drive(6'b100000, 32'h0000_A001, 0, 0, 0, 0, "R11 conditional switches in wide");
        drive(6'b100000, 32'h0000_A002, 0, 0, 0, 0, "R11 conditional warns in wide");
        drive(6'b000011, 32'h0000_B000, 0, 0, 0, 0, "R12 load beats step");
        drive(6'b011010, 32'h0000_C001, 0, 0, 0, 0, "R12 step beats branches");
        drive(6'b110000, 32'h0000_D002, 0, 0, 0, 0, "R12 switch branch beats conditional");
        drive(6'b000000, '0, 1, 0, 1, 1, "R13 set extension only");
        drive(6'b000100, '0, 0, 0, 0, 0, "R5 sequence end copies flags");
        drive(6'b100000, 32'h0000_E003, 0, 0, 0, 0, "R11 conditional plain with extension set");
        idle("R1 final idle");
        idle("R1 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule